// File: doc/BRIEF.md
# Memory Slowdown Estimator

This block watches a shared memory controller and estimates, for every core, how much slower that core runs because other cores compete for memory. Time is cut into fixed intervals, and each interval into equal epochs. At every epoch boundary a pseudo-random generator names one core as the favoured core, and the block drives that choice to the scheduler. While a core is favoured, the requests it gets served approximate its alone-mode service rate. Cycles in which it still waits behind another core's earlier issue are subtracted from that sample.

Per core the block counts serviced requests, memory stall cycles, favoured cycles, requests served while favoured, and interference cycles. At the last cycle of an interval all counters are latched and cleared. One bit-serial divider per core then forms a slowdown figure in unsigned fixed point with 8 fractional bits. A single valid pulse announces the whole vector once every divider has finished.

Top module: `mem_slowdown_est`

## Requirements
- R1: `prio_core_o` is 0 after reset, is always below NUM_CORES, and changes only on the first cycle of an epoch, so it holds for EPOCH_LEN cycles. The first epoch starts on the first cycle after reset is released.
- R2: The favoured core is drawn pseudo-randomly at every epoch boundary, and over many epochs every core is chosen.
- R3: Per core, the served count S is the number of interval cycles with its `served_i` bit high, and the stall count T is the number with its `stalled_i` bit high.
- R4: Per core, the favoured-cycle count H and the favoured-request count Q advance only in cycles in which `prio_core_o` equals that core. Q counts the cycles with `served_i` high among those.
- R5: An interference cycle I is counted for the favoured core when its `waiting_i` bit and `other_issued_i` are both high. The effective favoured time is E = H − I.
- R6: With L = EPOCH_LEN × EPOCHS_PER_INT, the result of core c is floor((L−T)·256/L) + floor(T·Q·256/(E·S)), clamped to 2^OUT_W−1. It sits in `slowdown_o[c*OUT_W +: OUT_W]`.
- R7: A core with S = 0 or E = 0 reports all ones.
- R8: T = 0 yields exactly 256 (1.0), provided S and E are nonzero. T = L reduces the result to floor(Q·256·L/(E·S)).
- R9: All counters clear at the interval boundary, so each result depends only on the cycles of its own interval.
- R10: `slowdown_valid_o` is a one-cycle pulse in cycle K + 2·CW + 10, where K is the interval's last cycle and CW = clog2(L+1). `slowdown_o` holds its value between pulses.
- R11: During reset, `slowdown_o` is 0 and `slowdown_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| served_i | input | NUM_CORES | Per-core strobe: one request of that core completed this cycle |
| stalled_i | input | NUM_CORES | Per-core flag: core is stalled on memory this cycle |
| waiting_i | input | NUM_CORES | Per-core flag: a request of that core sits in the request buffer |
| other_issued_i | input | 1 | The previously issued request came from a core other than the favoured one |
| prio_core_o | output | clog2(NUM_CORES) | Core given highest memory priority in the current epoch |
| slowdown_o | output | NUM_CORES*OUT_W | Per-core slowdown, 8 fractional bits |
| slowdown_valid_o | output | 1 | One-cycle pulse when `slowdown_o` is updated |

## Verification
The bench builds the block with three cores, epochs of 8 cycles and 4 epochs per interval. The non-power-of-two core count selects the modulo path of the random pick. The 32-cycle interval is short enough that favoured-core counts of zero, full stall and full interference all occur within a few intervals. A 20-step divider fits well inside one interval, so the gap between the valid pulse and the next interval's latch is exercised on every interval.

// File: rtl/sde_pkg.sv
package sde_pkg;
   // Galois feedback masks for maximal-length shift registers of selected widths
   function automatic logic [31:0] lfsr_mask(input int width);
      case (width)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sde_epoch_pick.sv
module sde_epoch_pick #(
   parameter int          NUM_CORES = 4,
   parameter int          LFSR_W    = 16,
   parameter int unsigned LFSR_SEED = 32'h0000_ACE1,
   localparam int         IDW       = $clog2(NUM_CORES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           epoch_end_i,
   output logic [IDW-1:0] prio_o
);
   import sde_pkg::*;

   localparam logic [LFSR_W-1:0] MASK = LFSR_W'(lfsr_mask(LFSR_W));
   localparam logic [LFSR_W-1:0] SEED = LFSR_W'(LFSR_SEED);

   logic [LFSR_W-1:0] lfsr_q, lfsr_nxt;
   logic [IDW-1:0]    prio_q, pick;

   assign lfsr_nxt = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? MASK : '0);

   generate
      if (is_pow2(NUM_CORES)) begin : g_mask_pick
         assign pick = lfsr_nxt[IDW-1:0];
      end else begin : g_mod_pick
         assign pick = IDW'(lfsr_nxt % LFSR_W'(NUM_CORES));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lfsr_q <= SEED;
         prio_q <= '0;
      end else begin
         lfsr_q <= lfsr_nxt;
         if (epoch_end_i) prio_q <= pick;
      end
   end

   assign prio_o = prio_q;

   assert_prio_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      prio_q < IDW'(NUM_CORES - 1) || prio_q == IDW'(NUM_CORES - 1));
   assert_prio_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !epoch_end_i |=> $stable(prio_q));
   assert_lfsr_alive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);
endmodule

// File: rtl/sde_core_ctr.sv
module sde_core_ctr #(
   parameter int  IL      = 128,
   parameter int  FRAC_W  = 8,
   localparam int IL_LOG2 = $clog2(IL),
   localparam int CNT_W   = $clog2(IL + 1),
   localparam int NUM_W   = 2 * CNT_W + FRAC_W,
   localparam int DEN_W   = 2 * CNT_W,
   localparam int BASE_W  = CNT_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_end_i,
   input  logic              is_prio_i,
   input  logic              served_i,
   input  logic              stalled_i,
   input  logic              waiting_i,
   input  logic              other_i,
   output logic [NUM_W-1:0]  num_o,
   output logic [DEN_W-1:0]  den_o,
   output logic [FRAC_W:0]   base_o,
   output logic              sat_o
);
   logic [CNT_W-1:0] srv_q, stl_q, hpr_q, hpc_q, itf_q;
   logic [CNT_W-1:0] srv_n, stl_n, hpr_n, hpc_n, itf_n, eff_n;
   logic [BASE_W-1:0] idle_scaled;
   logic [FRAC_W:0]   base_q;
   logic              sat_q;

   always_comb begin
      srv_n = srv_q + CNT_W'(served_i);
      stl_n = stl_q + CNT_W'(stalled_i);
      hpc_n = hpc_q + CNT_W'(is_prio_i);
      hpr_n = hpr_q + CNT_W'(is_prio_i & served_i);
      itf_n = itf_q + CNT_W'(is_prio_i & waiting_i & other_i);
      eff_n = hpc_n - itf_n;
   end

   // (1 - alpha) in fixed point: the interval length is a power of two
   assign idle_scaled = (BASE_W'(IL) - BASE_W'(stl_n)) << FRAC_W;

   // alpha * alone/shared collapses to T*Q / (E*S) because L cancels
   assign num_o = (NUM_W'(stl_n) * NUM_W'(hpr_n)) << FRAC_W;
   assign den_o = DEN_W'(eff_n) * DEN_W'(srv_n);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         srv_q  <= '0;
         stl_q  <= '0;
         hpr_q  <= '0;
         hpc_q  <= '0;
         itf_q  <= '0;
         base_q <= '0;
         sat_q  <= 1'b0;
      end else if (int_end_i) begin
         srv_q  <= '0;
         stl_q  <= '0;
         hpr_q  <= '0;
         hpc_q  <= '0;
         itf_q  <= '0;
         base_q <= (FRAC_W+1)'(idle_scaled >> IL_LOG2);
         sat_q  <= (srv_n == '0) || (eff_n == '0);
      end else begin
         srv_q <= srv_n;
         stl_q <= stl_n;
         hpr_q <= hpr_n;
         hpc_q <= hpc_n;
         itf_q <= itf_n;
      end
   end

   assign base_o = base_q;
   assign sat_o  = sat_q;

   assert_itf_within_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
      itf_q <= hpc_q);
   assert_req_within_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hpr_q <= hpc_q);
   assert_prio_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_prio_i && !int_end_i) |=> ($stable(hpc_q) && $stable(hpr_q) && $stable(itf_q)));
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      srv_q < CNT_W'(IL) && stl_q < CNT_W'(IL) && hpc_q < CNT_W'(IL));
   assert_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int_end_i |=> (srv_q == '0 && stl_q == '0 && hpc_q == '0));
endmodule

// File: rtl/sde_divider.sv
module sde_divider #(
   parameter int  NUM_W = 20,
   parameter int  DEN_W = 12,
   localparam int CTW   = $clog2(NUM_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic [NUM_W-1:0] quo_o,
   output logic             done_o
);
   logic [NUM_W-1:0] quo_q;
   logic [DEN_W-1:0] rem_q, den_q;
   logic [CTW-1:0]   cnt_q;
   logic             done_q;
   logic [DEN_W:0]   rem_sh, rem_sub;
   logic             fits;

   assign rem_sh  = {rem_q, quo_q[NUM_W-1]};
   assign rem_sub = rem_sh - {1'b0, den_q};
   assign fits    = rem_sh >= {1'b0, den_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            quo_q <= num_i;
            rem_q <= '0;
            den_q <= den_i;
            cnt_q <= CTW'(NUM_W);
         end else if (cnt_q != '0) begin
            quo_q  <= {quo_q[NUM_W-2:0], fits};
            rem_q  <= fits ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
            cnt_q  <= cnt_q - 1'b1;
            done_q <= (cnt_q == CTW'(1));
         end
      end
   end

   assign quo_o  = quo_q;
   assign done_o = done_q;

   assert_idle_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> cnt_q == '0);
   assert_done_finished_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (cnt_q == '0 && !$past(start_i)));
endmodule

// File: rtl/mem_slowdown_est.sv
module mem_slowdown_est #(
   parameter int          NUM_CORES      = 4,
   parameter int          EPOCH_LEN      = 16,
   parameter int          EPOCHS_PER_INT = 8,
   parameter int          FRAC_W         = 8,
   parameter int          OUT_W          = 16,
   parameter int          LFSR_W         = 16,
   parameter int unsigned LFSR_SEED      = 32'h0000_ACE1,
   localparam int         IDW            = $clog2(NUM_CORES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CORES-1:0]       served_i,
   input  logic [NUM_CORES-1:0]       stalled_i,
   input  logic [NUM_CORES-1:0]       waiting_i,
   input  logic                       other_issued_i,
   output logic [IDW-1:0]             prio_core_o,
   output logic [NUM_CORES*OUT_W-1:0] slowdown_o,
   output logic                       slowdown_valid_o
);
   import sde_pkg::*;

   localparam int IL     = EPOCH_LEN * EPOCHS_PER_INT;
   localparam int CNT_W  = $clog2(IL + 1);
   localparam int NUM_W  = 2 * CNT_W + FRAC_W;
   localparam int DEN_W  = 2 * CNT_W;
   localparam int SUM_W  = NUM_W + 1;
   localparam int EPW    = $clog2(EPOCH_LEN);
   localparam int EPNW   = $clog2(EPOCHS_PER_INT);

   // elaboration-time parameter checks
   if (NUM_CORES < 2) begin : g_chk_cores
      $error("NUM_CORES must be at least 2");
   end
   if (!is_pow2(EPOCH_LEN) || EPOCH_LEN < 2) begin : g_chk_epoch
      $error("EPOCH_LEN must be a power of two, at least 2");
   end
   if (!is_pow2(EPOCHS_PER_INT) || EPOCHS_PER_INT < 2) begin : g_chk_epochs
      $error("EPOCHS_PER_INT must be a power of two, at least 2");
   end
   if (IL <= NUM_W + 2) begin : g_chk_latency
      $error("interval too short for the divider latency");
   end
   if (lfsr_mask(LFSR_W) == 0) begin : g_chk_lfsr
      $error("LFSR_W must be 8, 16, 24 or 32");
   end
   if (LFSR_SEED == 0) begin : g_chk_seed
      $error("LFSR_SEED must be nonzero");
   end
   if (OUT_W <= FRAC_W) begin : g_chk_out
      $error("OUT_W must exceed FRAC_W");
   end

   logic [EPW-1:0]  ep_q;
   logic [EPNW-1:0] epn_q;
   logic            epoch_end, int_end;
   logic [IDW-1:0]  prio;

   assign epoch_end = (ep_q == EPW'(EPOCH_LEN - 1));
   assign int_end   = epoch_end && (epn_q == EPNW'(EPOCHS_PER_INT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ep_q  <= '0;
         epn_q <= '0;
      end else begin
         ep_q <= ep_q + 1'b1;
         if (epoch_end) epn_q <= epn_q + 1'b1;
      end
   end

   sde_epoch_pick #(
      .NUM_CORES (NUM_CORES),
      .LFSR_W    (LFSR_W),
      .LFSR_SEED (LFSR_SEED)
   ) pick_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .epoch_end_i (epoch_end),
      .prio_o      (prio)
   );

   logic [NUM_CORES-1:0]       done_v;
   logic [NUM_CORES-1:0]       sat_v;
   logic [NUM_CORES*OUT_W-1:0] res_v;
   logic [NUM_CORES*OUT_W-1:0] sd_q;
   logic                       valid_q;
   logic                       all_done;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CORES; gi++) begin : g_core
         logic [NUM_W-1:0]  num, quo;
         logic [DEN_W-1:0]  den;
         logic [FRAC_W:0]   base;
         logic [SUM_W-1:0]  sum;

         sde_core_ctr #(
            .IL     (IL),
            .FRAC_W (FRAC_W)
         ) ctr_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .int_end_i (int_end),
            .is_prio_i (prio == IDW'(gi)),
            .served_i  (served_i[gi]),
            .stalled_i (stalled_i[gi]),
            .waiting_i (waiting_i[gi]),
            .other_i   (other_issued_i),
            .num_o     (num),
            .den_o     (den),
            .base_o    (base),
            .sat_o     (sat_v[gi])
         );

         sde_divider #(
            .NUM_W (NUM_W),
            .DEN_W (DEN_W)
         ) div_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (int_end),
            .num_i   (num),
            .den_i   (den),
            .quo_o   (quo),
            .done_o  (done_v[gi])
         );

         assign sum = SUM_W'(base) + SUM_W'(quo);

         if (SUM_W > OUT_W) begin : g_clamp
            localparam logic [SUM_W-1:0] LIMIT = SUM_W'({OUT_W{1'b1}});
            assign res_v[gi*OUT_W +: OUT_W] =
               (sat_v[gi] || sum > LIMIT) ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
         end else begin : g_wide
            assign res_v[gi*OUT_W +: OUT_W] =
               sat_v[gi] ? {OUT_W{1'b1}} : OUT_W'(sum);
         end
      end
   endgenerate

   assign all_done = &done_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sd_q    <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= all_done;
         if (all_done) sd_q <= res_v;
      end
   end

   assign prio_core_o      = prio;
   assign slowdown_o       = sd_q;
   assign slowdown_valid_o = valid_q;

   assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);
   assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> $stable(sd_q) || $past(all_done));
   assert_dividers_lockstep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_v == '0 || all_done);
   assert_no_end_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      int_end |-> !all_done);
endmodule

// File: tb/mem_slowdown_est_tb_top.sv
module mem_slowdown_est_tb_top;
   localparam int N   = 3;
   localparam int EL  = 8;
   localparam int EPI = 4;
   localparam int FW  = 8;
   localparam int OW  = 16;
   localparam int IL  = EL * EPI;
   localparam int CW  = $clog2(IL + 1);
   localparam int LAT = 2 * CW + FW + 2;
   localparam int NINT = 40;
   localparam int IDW = $clog2(N);

   logic              clk = 1'b0;
   logic              rst_n;
   logic [N-1:0]      served, stalled, waiting;
   logic              other;
   logic [IDW-1:0]    prio;
   logic [N*OW-1:0]   sd;
   logic              sd_valid;

   always #5 clk = ~clk;

   mem_slowdown_est #(
      .NUM_CORES      (N),
      .EPOCH_LEN      (EL),
      .EPOCHS_PER_INT (EPI),
      .FRAC_W         (FW),
      .OUT_W          (OW)
   ) dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .served_i         (served),
      .stalled_i        (stalled),
      .waiting_i        (waiting),
      .other_issued_i   (other),
      .prio_core_o      (prio),
      .slowdown_o       (sd),
      .slowdown_valid_o (sd_valid)
   );

   int checks = 0;
   int fails  = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected result from the R6/R7 formula
   function automatic longint expect_sd(int st, int hr, int hc, int it, int sv);
      longint eff, base, ratio, s;
      eff = hc - it;
      if (sv == 0 || eff == 0) return 65535;
      base  = (longint'(IL - st) * 256) / IL;
      ratio = (longint'(st) * hr * 256) / (eff * sv);
      s = base + ratio;
      if (s > 65535) s = 65535;
      return s;
   endfunction

   int     m_srv[N], m_stl[N], m_hpr[N], m_hpc[N], m_itf[N];
   longint exp_sd[N];
   string  exp_tag;
   int     last_end = -1000;
   int     prev_prio = 0;
   int     prio_changes = 0;
   bit     seen[N];
   logic [N*OW-1:0] held;

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int unsigned seed_val;
      string tags[8];
      seed_val = $urandom(32'd20240607);
      tags = '{"R3 R6", "R7", "R8", "R8", "R5", "R5 R7", "R9", "R4"};
      rst_n = 1'b0; served = '0; stalled = '0; waiting = '0; other = 1'b0;
      held = '0;
      for (int c = 0; c < N; c++) begin
         m_srv[c] = 0; m_stl[c] = 0; m_hpr[c] = 0; m_hpc[c] = 0; m_itf[c] = 0;
         seen[c] = 1'b0; exp_sd[c] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(sd == '0, "R11 slowdown in reset", longint'(sd), 0);
      check(sd_valid == 1'b0, "R11 valid in reset", longint'(sd_valid), 0);
      rst_n = 1'b1;

      for (int k = 0; k < NINT * IL + LAT + 4; k++) begin
         int  mode;
         bit  exp_v;
         // observe outputs of cycle k
         exp_v = (k == last_end + LAT);
         check(sd_valid == exp_v, "R10 valid timing", longint'(sd_valid), longint'(exp_v));
         if (sd_valid) begin
            for (int c = 0; c < N; c++)
               check(longint'(sd[c*OW +: OW]) == exp_sd[c], exp_tag,
                     longint'(sd[c*OW +: OW]), exp_sd[c]);
            held = sd;
         end else begin
            check(sd == held, "R10 result held", longint'(sd), longint'(held));
         end
         check(int'(prio) < N, "R1 favoured id in range", longint'(prio), N - 1);
         if (k == 0)
            check(prio == '0, "R11 favoured id after reset (R1)", longint'(prio), 0);
         else if (k % EL != 0)
            check(int'(prio) == prev_prio, "R1 favoured id held in epoch",
                  longint'(prio), longint'(prev_prio));
         else if (int'(prio) != prev_prio)
            prio_changes++;
         prev_prio = int'(prio);
         seen[prio] = 1'b1;

         if (k >= NINT * IL) begin
            served = '0; stalled = '0; waiting = '0; other = 1'b0;
            @(negedge clk);
            continue;
         end

         // drive stimulus for cycle k
         mode    = (k / IL) % 8;
         served  = N'($urandom);
         stalled = N'($urandom);
         waiting = N'($urandom);
         other   = 1'($urandom);
         case (mode)
            1: served[1] = 1'b0;
            2: stalled = '1;
            3: stalled = '0;
            4: other = 1'b0;
            5: begin waiting = '1; other = 1'b1; end
            7: served[prio] = 1'b0;
            default: ;
         endcase

         for (int c = 0; c < N; c++) begin
            m_srv[c] += served[c];
            m_stl[c] += stalled[c];
            if (int'(prio) == c) begin
               m_hpc[c]++;
               m_hpr[c] += served[c];
               if (waiting[c] && other) m_itf[c]++;
            end
         end

         if (k % IL == IL - 1) begin
            for (int c = 0; c < N; c++) begin
               exp_sd[c] = expect_sd(m_stl[c], m_hpr[c], m_hpc[c], m_itf[c], m_srv[c]);
               m_srv[c] = 0; m_stl[c] = 0; m_hpr[c] = 0; m_hpc[c] = 0; m_itf[c] = 0;
            end
            exp_tag  = tags[mode];
            last_end = k;
         end
         @(negedge clk);
      end

      for (int c = 0; c < N; c++)
         check(seen[c], "R2 every core favoured", longint'(seen[c]), 1);
      check(prio_changes > 0, "R2 favoured id changes", prio_changes, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule